// File: doc/BRIEF.md
# I2C Register-Access Transaction Sequencer

This block runs whole register transactions for an I2C master. A client hands it one request: a 7-bit slave address, a register byte, a direction, a byte count and a raw-access flag. The block then drives a bit-level I2C engine one byte-level command at a time. The commands are start, stop, write a byte, and read a byte with a chosen acknowledge bit. After each command it waits for the engine's completion event, and it reports success or failure when the transaction ends.

Write payload arrives on a valid/ready byte stream and read payload leaves on another. Reads set the slave's register pointer first and then turn the bus round with a repeated start. A register value of 0xFF combined with the raw flag drops the register phase for slaves that have no register pointer. A slave NACK ends the transaction with a stop. Every wait for the engine is guarded by a cycle budget. When that budget runs out, the block asks for bus recovery and returns to idle with a failure.

Top module: `i2c_xact_seq`

## Requirements
- R1: An address byte carries the 7-bit slave address in bits 7..1 and the direction in bit 0, where 0 means write and 1 means read.
- R2: Commands use the encoding start=0, stop=1, write-byte=2, read-byte=3. A write transaction issues start, the address with bit 0 clear, the register byte, each payload byte in stream order, and then stop.
- R3: A read transaction of N>0 bytes issues start, the address with bit 0 clear, the register byte, a second start, the address with bit 0 set, N read-byte commands, and then stop.
- R4: When the register byte is 0xFF and raw access is requested, the register byte is not sent. A read then goes straight from the first start to the address with bit 0 set, and a write goes from the address straight to payload. With any other register value, or with raw access off, the normal sequence applies.
- R5: A read of length 0 issues stop directly after the register byte, with no second start. A write of length 0 issues stop after the register byte. Both end with ok=1.
- R6: Each read-byte command asks for ACK (cmd_nack=0), except the last one of the transaction, which asks for NACK (cmd_nack=1). The received bytes leave on the read stream in bus order.
- R7: A completion with ev_nack=1 on an address, register or payload byte makes the next command a stop, and the transaction ends with ok=0.
- R8: Each wait for a completion event lasts at most TMO_CYC cycles. If no event arrives, bus_recover pulses for one cycle, TMO_CYC+1 cycles after the command was issued. done then follows in the next cycle with ok=0. A stop wait that runs out of time fails in the same way.
- R9: done rises for one cycle, exactly one cycle after the completion of the final stop, and ok is valid with it.
- R10: A request is taken only while req_ready is high, which happens only in idle. A request offered during a transaction has no effect on the command sequence.
- R11: A byte on the read stream stays valid and unchanged until rd_ready accepts it, and the next read-byte command waits for that acceptance.
- R12: The wait budget restarts for every command. An engine that answers each command exactly TMO_CYC cycles after it was issued never causes a timeout, however long the transaction is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_addr | input | 7 | 7-bit slave address |
| req_reg | input | 8 | Register byte (0xFF with raw flag: none) |
| req_read | input | 1 | 1 = read, 0 = write |
| req_len | input | LEN_W | Payload byte count |
| req_raw | input | 1 | Permit the register-less form |
| wr_valid | input | 1 | Write payload byte valid |
| wr_ready | output | 1 | Write payload byte accepted |
| wr_data | input | 8 | Write payload byte |
| rd_valid | output | 1 | Read payload byte valid |
| rd_ready | input | 1 | Read payload byte accepted |
| rd_data | output | 8 | Read payload byte |
| cmd_valid | output | 1 | One-cycle command to the bit engine |
| cmd_op | output | 2 | Command code (see R2) |
| cmd_byte | output | 8 | Byte to transmit for write-byte |
| cmd_nack | output | 1 | Acknowledge bit to send after a read-byte |
| ev_done | input | 1 | Engine finished the last command |
| ev_nack | input | 1 | Slave did not acknowledge the byte |
| ev_byte | input | 8 | Byte received by a read-byte |
| bus_recover | output | 1 | Pulse asking for bus recovery and reinit |
| done | output | 1 | Transaction finished pulse |
| ok | output | 1 | Transaction result, valid with done |

## Verification
Most internal faults in this block show up on the command port, usually at the very next command. A wrong phase, a wrong direction bit or a lost register skip all change the op, byte or acknowledge of that command. A miscounted remaining length also shows there, as an early or late stop or a misplaced NACK. Faults in the timer or the result flag show up later, in the cycle where bus_recover or done rises or in the value of ok. The bench therefore compares every issued command against a behavioural expectation, in the same cycle it appears, and times the done and recovery pulses to the exact cycle.

// File: rtl/i2c_seq_pkg.sv
// Shared types for the I2C transaction sequencer.
// Assumes 7-bit addressing and byte-wide payload.
package i2c_seq_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam logic [BYTE_W-1:0] NO_REG = 8'hFF;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_FETCH,
        S_RDHOLD,
        S_BUSERR
    } seq_state_e;

    typedef enum logic [2:0] {
        PH_START,
        PH_WADDR,
        PH_REG,
        PH_RSTART,
        PH_RADDR,
        PH_WDATA,
        PH_RDATA,
        PH_STOP
    } seq_phase_e;
endpackage

// File: rtl/i2c_seq_timer.sv
// Wait-budget counter: counts cycles while run is high, clears when it drops.
// expired is high in the last allowed cycle of a wait (count TMO_CYC-1).
// Assumes TMO_CYC >= 2.
module i2c_seq_timer #(
    parameter int TMO_CYC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TMO_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

    logic [CW-1:0] cnt;

    // Count wait cycles, restart whenever the wait ends.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Flag the final cycle of the budget.
    always_comb expired = run && (cnt == LAST);

    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    p_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));
endmodule

// File: rtl/i2c_seq_count.sv
// Remaining-payload counter: loaded with the request length, decremented
// per byte moved. Assumes no decrement at zero.
module i2c_seq_count #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic             is_zero,
    output logic             is_one
);
    logic [LEN_W-1:0] rem;

    // Hold the number of payload bytes still to move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
        end else if (load) begin
            rem <= load_val;
        end else if (dec) begin
            rem <= rem - 1'b1;
        end
    end

    // Decode the two counts the sequencer branches on.
    always_comb begin
        is_zero = (rem == '0);
        is_one  = (rem == LEN_W'(1));
    end

    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (rem != '0));
endmodule

// File: rtl/i2c_xact_seq.sv
// I2C register-access transaction sequencer.
// Turns one request into a string of byte-level commands for a bit engine,
// waits for a completion event after each one, and reports a result.
// Assumes the engine answers each command with exactly one ev_done pulse,
// and ignores ev_done when no command is outstanding.
module i2c_xact_seq
    import i2c_seq_pkg::*;
#(
    parameter int LEN_W   = 8,
    parameter int TMO_CYC = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BYTE_W-1:0] req_reg,
    input  logic              req_read,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_raw,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [BYTE_W-1:0] rd_data,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [BYTE_W-1:0] cmd_byte,
    output logic              cmd_nack,
    input  logic              ev_done,
    input  logic              ev_nack,
    input  logic [BYTE_W-1:0] ev_byte,
    output logic              bus_recover,
    output logic              done,
    output logic              ok
);
    seq_state_e        state;
    seq_phase_e        phase;
    logic [ADDR_W-1:0] addr_q;
    logic [BYTE_W-1:0] reg_q;
    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] rx_q;
    logic              read_q;
    logic              skip_q;
    logic              ok_q;
    logic              done_q;
    logic              okout_q;

    logic accept;
    logic tmo_hit;
    logic len_zero;
    logic len_one;
    logic cnt_dec;
    logic ack_ok;

    // Request handshake and completion qualifier.
    always_comb begin
        req_ready = (state == S_IDLE);
        accept    = req_valid && req_ready;
        ack_ok    = ev_done && !ev_nack;
        cnt_dec   = (state == S_WAIT && phase == PH_WDATA && ack_ok) ||
                    (state == S_RDHOLD && rd_ready);
    end

    i2c_seq_timer #(.TMO_CYC(TMO_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == S_WAIT),
        .expired (tmo_hit)
    );

    i2c_seq_count #(.LEN_W(LEN_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (req_len),
        .dec      (cnt_dec),
        .is_zero  (len_zero),
        .is_one   (len_one)
    );

    // Drive the engine command from the current phase.
    always_comb begin
        cmd_valid = (state == S_ISSUE);
        cmd_nack  = 1'b0;
        cmd_byte  = '0;
        unique case (phase)
            PH_START, PH_RSTART: cmd_op = OP_START;
            PH_STOP:             cmd_op = OP_STOP;
            PH_RDATA: begin
                cmd_op   = OP_READ;
                cmd_nack = len_one;
            end
            PH_WADDR: begin
                cmd_op   = OP_WRITE;
                cmd_byte = {addr_q, 1'b0};
            end
            PH_RADDR: begin
                cmd_op   = OP_WRITE;
                cmd_byte = {addr_q, 1'b1};
            end
            PH_REG: begin
                cmd_op   = OP_WRITE;
                cmd_byte = reg_q;
            end
            default: begin
                cmd_op   = OP_WRITE;
                cmd_byte = tx_q;
            end
        endcase
    end

    // Stream and status outputs.
    always_comb begin
        wr_ready    = (state == S_FETCH);
        rd_valid    = (state == S_RDHOLD);
        rd_data     = rx_q;
        bus_recover = (state == S_BUSERR);
        done        = done_q;
        ok          = okout_q;
    end

    // Sequence the transaction phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            phase   <= PH_START;
            addr_q  <= '0;
            reg_q   <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            read_q  <= 1'b0;
            skip_q  <= 1'b0;
            ok_q    <= 1'b0;
            done_q  <= 1'b0;
            okout_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (accept) begin
                        addr_q <= req_addr;
                        reg_q  <= req_reg;
                        read_q <= req_read;
                        skip_q <= req_raw && (req_reg == NO_REG);
                        ok_q   <= 1'b0;
                        phase  <= PH_START;
                        state  <= S_ISSUE;
                    end
                end
                S_ISSUE: state <= S_WAIT;
                S_FETCH: begin
                    if (wr_valid) begin
                        tx_q  <= wr_data;
                        state <= S_ISSUE;
                    end
                end
                S_RDHOLD: begin
                    if (rd_ready) begin
                        state <= S_ISSUE;
                        if (len_one) begin
                            ok_q  <= 1'b1;
                            phase <= PH_STOP;
                        end else begin
                            phase <= PH_RDATA;
                        end
                    end
                end
                S_BUSERR: begin
                    done_q  <= 1'b1;
                    okout_q <= 1'b0;
                    state   <= S_IDLE;
                end
                S_WAIT: begin
                    if (ev_done) begin
                        state <= S_ISSUE;
                        if (ev_nack && phase inside {PH_WADDR, PH_REG, PH_RADDR, PH_WDATA}) begin
                            ok_q  <= 1'b0;
                            phase <= PH_STOP;
                        end else begin
                            unique case (phase)
                                PH_START: phase <= (read_q && skip_q) ? PH_RADDR : PH_WADDR;
                                PH_WADDR: begin
                                    if (!skip_q) begin
                                        phase <= PH_REG;
                                    end else if (len_zero) begin
                                        ok_q  <= 1'b1;
                                        phase <= PH_STOP;
                                    end else begin
                                        phase <= PH_WDATA;
                                        state <= S_FETCH;
                                    end
                                end
                                PH_REG: begin
                                    if (len_zero) begin
                                        ok_q  <= 1'b1;
                                        phase <= PH_STOP;
                                    end else if (read_q) begin
                                        phase <= PH_RSTART;
                                    end else begin
                                        phase <= PH_WDATA;
                                        state <= S_FETCH;
                                    end
                                end
                                PH_RSTART: phase <= PH_RADDR;
                                PH_RADDR: begin
                                    if (len_zero) begin
                                        ok_q  <= 1'b1;
                                        phase <= PH_STOP;
                                    end else begin
                                        phase <= PH_RDATA;
                                    end
                                end
                                PH_WDATA: begin
                                    if (len_one) begin
                                        ok_q  <= 1'b1;
                                        phase <= PH_STOP;
                                    end else begin
                                        state <= S_FETCH;
                                    end
                                end
                                PH_RDATA: begin
                                    rx_q  <= ev_byte;
                                    state <= S_RDHOLD;
                                end
                                default: begin
                                    done_q  <= 1'b1;
                                    okout_q <= ok_q;
                                    state   <= S_IDLE;
                                end
                            endcase
                        end
                    end else if (tmo_hit) begin
                        state <= S_BUSERR;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    p_accept_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    p_cmd_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    p_recover_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_recover |=> (done && !ok));
    p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/i2c_xact_seq_tb.sv
`timescale 1ns/1ps
module i2c_xact_seq_tb_top;
    localparam int TMO = 16;
    localparam int LW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          req_valid = 0, req_read = 0, req_raw = 0;
    logic [6:0]    req_addr = 0;
    logic [7:0]    req_reg = 0;
    logic [LW-1:0] req_len = 0;
    logic          wr_valid = 0, rd_ready = 0;
    logic [7:0]    wr_data = 0;
    logic          ev_done = 0, ev_nack = 0;
    logic [7:0]    ev_byte = 0;
    logic          req_ready, wr_ready, rd_valid, cmd_valid, cmd_nack;
    logic          bus_recover, done, ok;
    logic [7:0]    rd_data, cmd_byte;
    logic [1:0]    cmd_op;

    i2c_xact_seq #(.LEN_W(LW), .TMO_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_reg(req_reg), .req_read(req_read), .req_len(req_len), .req_raw(req_raw),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_nack(cmd_nack),
        .ev_done(ev_done), .ev_nack(ev_nack), .ev_byte(ev_byte),
        .bus_recover(bus_recover), .done(done), .ok(ok)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Expected model state for the running transaction.
    logic [10:0] exp_q[$];
    logic [7:0]  wr_q[$];
    logic [7:0]  rd_exp[$];
    logic        exp_ok;
    string       tag;
    int          nack_at, hang_at, lat;
    int          idx, pend, rx_k;
    logic        pend_nack, pend_stop;
    logic [7:0]  pend_byte;
    int          hang_cyc, rec_cyc, stop_cyc;
    logic        done_seen;

    task automatic chk(input logic cond, input string t, input string what,
                       input int act, input int expv);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, expv);
        end
    endtask

    // Handshake sampling at the active edge.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && wr_valid && wr_ready && wr_q.size() > 0) void'(wr_q.pop_front());
        if (rst_n && rd_valid && rd_ready) begin
            if (rd_exp.size() == 0) chk(1'b0, "R6", "unexpected read byte", rd_data, 0);
            else begin
                logic [7:0] e;
                e = rd_exp.pop_front();
                chk(rd_data == e, "R11", "read stream byte", rd_data, e);
            end
        end
    end

    // Responder, stream drivers and per-clock monitor.
    always @(negedge clk) begin
        ev_done = 0;
        ev_nack = 0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                ev_done = 1;
                ev_nack = pend_nack;
                ev_byte = pend_byte;
                if (pend_stop) stop_cyc = cyc;
            end
        end
        if (rst_n && cmd_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, tag, "unexpected command", {cmd_op, cmd_byte, cmd_nack}, 0);
            end else begin
                logic [10:0] e;
                e = exp_q.pop_front();
                chk({cmd_op, cmd_byte, cmd_nack} == e, tag, "command {op,byte,nack}",
                    {cmd_op, cmd_byte, cmd_nack}, e);
            end
            if (idx == hang_at) begin
                hang_cyc = cyc;
            end else begin
                pend      = lat;
                pend_nack = (idx == nack_at);
                pend_stop = (cmd_op == 2'd1);
                pend_byte = 8'hC0 + 8'(rx_k);
                if (cmd_op == 2'd3) rx_k++;
            end
            idx++;
        end
        if (rst_n && bus_recover) begin
            rec_cyc = cyc;
            chk(hang_at >= 0, "R8", "recover without hang", 1, 0);
            chk(cyc - hang_cyc == TMO + 1, "R8", "recover delay", cyc - hang_cyc, TMO + 1);
        end
        if (rst_n && done) begin
            done_seen = 1;
            chk(ok == exp_ok, tag, "ok result", ok, exp_ok);
            chk(exp_q.size() == 0, tag, "commands missing at done", exp_q.size(), 0);
            chk(rd_exp.size() == 0, "R6", "read bytes missing", rd_exp.size(), 0);
            if (hang_at >= 0) chk(cyc == rec_cyc + 1, "R8", "done after recover", cyc, rec_cyc + 1);
            else chk(cyc == stop_cyc + 1, "R9", "done after stop ack", cyc, stop_cyc + 1);
        end
        wr_valid = (wr_q.size() > 0) && (cyc % 4 != 1);
        wr_data  = (wr_q.size() > 0) ? wr_q[0] : 8'h00;
        rd_ready = (cyc % 3 != 0);
    end

    task automatic run_txn(input string t, input logic [6:0] a, input logic [7:0] r,
                           input logic rd, input int len, input logic raw,
                           input int nk, input int hg, input int lt, input int spam);
        logic skip;
        int   rxn;
        skip = raw && (r == 8'hFF);
        exp_q.delete(); wr_q.delete(); rd_exp.delete();
        exp_q.push_back({2'd0, 8'h00, 1'b0});
        if (!(rd && skip)) exp_q.push_back({2'd2, a, 1'b0, 1'b0});
        if (!skip) exp_q.push_back({2'd2, r, 1'b0});
        if (rd) begin
            if (!(len == 0 && !skip)) begin
                if (!skip) exp_q.push_back({2'd0, 8'h00, 1'b0});
                exp_q.push_back({2'd2, a, 1'b1, 1'b0});
                for (int i = 0; i < len; i++) exp_q.push_back({2'd3, 8'h00, i == len - 1});
            end
        end else begin
            for (int i = 0; i < len; i++) begin
                exp_q.push_back({2'd2, 8'h30 + 8'(i) + 8'(a), 1'b0});
                wr_q.push_back(8'h30 + 8'(i) + 8'(a));
            end
        end
        exp_q.push_back({2'd1, 8'h00, 1'b0});
        exp_ok = 1;
        if (nk >= 0) begin
            while (exp_q.size() > nk + 1) void'(exp_q.pop_back());
            exp_q.push_back({2'd1, 8'h00, 1'b0});
            exp_ok = 0;
        end
        if (hg >= 0) begin
            while (exp_q.size() > hg + 1) void'(exp_q.pop_back());
            exp_ok = 0;
        end
        rxn = 0;
        foreach (exp_q[i]) if (exp_q[i][10:9] == 2'd3) begin
            rd_exp.push_back(8'hC0 + 8'(rxn));
            rxn++;
        end
        tag = t; nack_at = nk; hang_at = hg; lat = lt;
        idx = 0; rx_k = 0; pend = 0; done_seen = 0;
        @(negedge clk);
        chk(req_ready == 1, "R10", "ready before request", req_ready, 1);
        req_valid = 1; req_addr = a; req_reg = r; req_read = rd;
        req_len = LW'(len); req_raw = raw;
        @(negedge clk);
        if (spam != 0) begin
            // R10: a different request held during the transaction.
            req_addr = 7'h11; req_reg = 8'hFF; req_read = ~rd; req_len = 8'd9; req_raw = 1;
            for (int k = 0; k < 10; k++) begin
                chk(req_ready == 0, "R10", "ready while busy", req_ready, 0);
                @(negedge clk);
            end
        end
        req_valid = 0;
        for (int k = 0; k < 3000 && !done_seen; k++) @(negedge clk);
        if (!done_seen) chk(1'b0, t, "transaction never finished", 0, 1);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        nack_at = -1; hang_at = -1; lat = 3; pend = 0; idx = 0; rx_k = 0;
        tag = "R10"; done_seen = 0; exp_ok = 0;
        hang_cyc = 0; rec_cyc = 0; stop_cyc = 0;
        pend_nack = 0; pend_stop = 0; pend_byte = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1, "R10", "reset ready", req_ready, 1);
        chk(cmd_valid == 0, "R2", "reset cmd_valid", cmd_valid, 0);
        chk(done == 0, "R9", "reset done", done, 0);
        chk(bus_recover == 0, "R8", "reset recover", bus_recover, 0);
        chk(rd_valid == 0 && wr_ready == 0, "R11", "reset streams", rd_valid, 0);
        run_txn("R2", 7'h50, 8'h22, 0, 3, 0, -1, -1, 3, 0);
        run_txn("R3", 7'h68, 8'h0F, 1, 4, 0, -1, -1, 3, 0);
        run_txn("R6", 7'h1E, 8'h75, 1, 1, 0, -1, -1, 2, 0);
        run_txn("R12", 7'h3C, 8'h41, 1, 2, 0, -1, -1, TMO, 0);
        run_txn("R4", 7'h2A, 8'hFF, 1, 2, 1, -1, -1, 3, 0);
        run_txn("R4", 7'h2B, 8'hFF, 0, 2, 1, -1, -1, 3, 0);
        run_txn("R4", 7'h2C, 8'h10, 0, 1, 1, -1, -1, 3, 0);
        run_txn("R4", 7'h2D, 8'hFF, 1, 1, 0, -1, -1, 3, 0);
        run_txn("R5", 7'h44, 8'h33, 1, 0, 0, -1, -1, 3, 0);
        run_txn("R5", 7'h45, 8'h34, 0, 0, 0, -1, -1, 3, 0);
        run_txn("R1", 7'h7F, 8'h01, 1, 1, 0, -1, -1, 1, 0);
        run_txn("R7", 7'h12, 8'h05, 0, 2, 0, 1, -1, 3, 0);
        run_txn("R7", 7'h13, 8'h06, 0, 3, 0, 3, -1, 3, 0);
        run_txn("R7", 7'h14, 8'h07, 1, 2, 0, 4, -1, 3, 0);
        run_txn("R8", 7'h15, 8'h08, 0, 1, 0, -1, 2, 3, 0);
        run_txn("R8", 7'h16, 8'h09, 0, 0, 0, -1, 3, 3, 0);
        run_txn("R10", 7'h17, 8'h0A, 1, 3, 0, -1, -1, 3, 1);
        run_txn("R2", 7'h01, 8'h00, 0, 1, 0, -1, -1, 3, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog for a hung run.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule